// File: doc/BRIEF.md
# Serial Configuration Memory Slave

This block is a three-wire serial slave in front of a 64-word by 16-bit store that is kept as a register array. A host selects it with an active-high select line. The host then shifts 9-bit commands in, one bit per rising serial clock. The commands cover word reads, streamed reads, single and page writes, single-word erase, fill of the whole array, and a write-protect latch. Programming is not immediate. A changed word reaches the array only when the command that carried it is deselected. After that the block stays busy for a fixed number of system clocks, set by a parameter. While it is busy, selecting it shows that state on the data output.

A second way in serves a host with little logic, such as the bus-interface chip next to the memory. A rising edge on the download-enable input arms the block. The next select then streams the whole array out from address 0 with no command. Every input is sampled on the system clock. A serial clock edge therefore takes effect at the first system clock edge where the new level is seen. The serial data output comes as a value and an enable, and the enable is low whenever the pin would float.

Top module: `serial_cfg_mem`

## Requirements
- R1: A command is a start bit of 1, then 2 opcode bits, then 6 address or extension bits, MSB first, sampled on rising `sclk`. Zeros on `sdi` before the start bit are skipped.
- R2: Opcode 10 reads. After the last address bit the output is enabled with a dummy 0. Each later rising `sclk` shows the next bit of the word, bit 15 first. `sdo_en` is low whenever `sel` is low, and whenever neither read data nor status is being shown.
- R3: If select stays high after a read word, the next rising edges stream the word at the next address with no new dummy bit. Address 63 is followed by address 0.
- R4: Opcode 01 takes 16 data bits after the address. Each further 16 bits goes to the next address. The low 3 address bits wrap from 7 to 0 and the upper 3 bits stay fixed, so at most one 8-word page is touched.
- R5: Writes, erase and fill start on the falling edge of `sel` and take `PROG_CYCLES` clocks. After such a start, `sel` high with no new start bit enables `sdo` = 0 while busy and `sdo` = 1 once ready. A start bit ends the status display.
- R6: After reset, writing is disabled. Opcode 00 with extension 11xxxx enables it and extension 00xxxx disables it. Write, erase and fill change nothing while writing is disabled. Reads always work.
- R7: Opcode 11 sets the addressed word to all ones. Opcode 00 with extension 01xxxx, followed by 16 data bits, writes that value to every word.
- R8: A rising edge on `dl_en` while it stays high arms download. The next rising `sel` enables a dummy 0, then array words from address 0 upward, one bit per rising `sclk`. The first falling `sel` ends download and disarms it.
- R9: A falling `sel` throws away any partly received command. The next access needs a new start bit.
- R10: A start bit received while busy is ignored, and so is the rest of that command.
- R11: Reset leaves `sdo_en` low, every word all ones and writing disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Chip select, active high |
| sclk | input | 1 | Serial clock, rising edge samples |
| sdi | input | 1 | Serial data in |
| dl_en | input | 1 | Download enable, armed by a rising edge |
| sdo | output | 1 | Serial data out value |
| sdo_en | output | 1 | Output enable for `sdo`; low means high impedance |

## Verification
The bench keeps the default geometry of 6 address bits and 3 page bits. This keeps the wrap from address 63 to 0 and the page wrap from slot 7 to slot 0 within a few commands. It sets `PROG_CYCLES` to 200. That is short enough for many programming runs, and long enough that a complete 9-bit command can be sent and ignored inside one busy window before the ready status is seen.

// File: rtl/mwm_pkg.sv
package mwm_pkg;

    // Serial front-end states
    typedef enum logic [2:0] {
        S_IDLE,
        S_OPC,
        S_ADR,
        S_RD,
        S_WDATA,
        S_SKIP
    } mw_state_e;

    // Two opcode bits following the start bit
    typedef enum logic [1:0] {
        OP_EXT   = 2'b00,
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10,
        OP_ERASE = 2'b11
    } mw_op_e;

    // Top two bits of the field that follows opcode 00
    typedef enum logic [1:0] {
        X_WPROT = 2'b00,
        X_FILL  = 2'b01,
        X_RSV   = 2'b10,
        X_WOPEN = 2'b11
    } mw_ext_e;

    // Programming job waiting in the staging area
    typedef enum logic [1:0] {
        K_NONE,
        K_PAGE,
        K_ERASE,
        K_FILL
    } mw_job_e;

endpackage

// File: rtl/mwm_sample_reg.sv
module mwm_sample_reg #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] din,
    output logic [N-1:0] dly
);
    // One-cycle delayed copy of the pins, for edge detection in the top
    always_ff @(posedge clk) begin
        if (rst) dly <= '0;
        else     dly <= din;
    end
endmodule

// File: rtl/mwm_prog_timer.sv
module mwm_prog_timer #(
    parameter int CYCLES = 2000
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic busy,
    output logic done
);
    localparam int TW = $clog2(CYCLES + 1);

    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)             cnt <= '0;
        else if (load)       cnt <= TW'(CYCLES);
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);
    assign done = (cnt == TW'(1));
endmodule

// File: rtl/mwm_store.sv
module mwm_store
    import mwm_pkg::*;
#(
    parameter int AW = 6,
    parameter int DW = 16,
    parameter int PB = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    input  logic          stg_word,
    input  logic          stg_erase,
    input  logic          stg_fill,
    input  logic [AW-1:0] stg_addr,
    input  logic [DW-1:0] stg_data,
    input  logic          commit,
    output logic          pending
);
    localparam int WORDS = 1 << AW;
    localparam int PSZ   = 1 << PB;
    localparam int UB    = AW - PB;

    logic [DW-1:0] mem  [WORDS];
    logic [DW-1:0] pbuf [PSZ];
    logic [PSZ-1:0] pmask;
    logic [UB-1:0]  pg;
    logic [AW-1:0]  eaddr;
    mw_job_e        job;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= '1;
            for (int i = 0; i < PSZ; i++)   pbuf[i] <= '0;
            pmask <= '0;
            pg    <= '0;
            eaddr <= '0;
            job   <= K_NONE;
        end else if (commit) begin
            unique case (job)
                K_PAGE: begin
                    for (int i = 0; i < PSZ; i++)
                        if (pmask[i]) mem[{pg, PB'(i)}] <= pbuf[i];
                end
                K_ERASE: mem[eaddr] <= '1;
                K_FILL: begin
                    for (int i = 0; i < WORDS; i++) mem[i] <= pbuf[0];
                end
                default: ;
            endcase
            job   <= K_NONE;
            pmask <= '0;
        end else begin
            if (stg_word) begin
                pbuf[stg_addr[PB-1:0]]  <= stg_data;
                pmask[stg_addr[PB-1:0]] <= 1'b1;
                pg  <= stg_addr[AW-1:PB];
                job <= K_PAGE;
            end
            if (stg_erase) begin
                eaddr <= stg_addr;
                job   <= K_ERASE;
            end
            if (stg_fill) begin
                pbuf[0] <= stg_data;
                job     <= K_FILL;
            end
        end
    end

    assign rd_data = mem[rd_addr];
    assign pending = (job != K_NONE);
endmodule

// File: rtl/serial_cfg_mem.sv
module serial_cfg_mem
    import mwm_pkg::*;
#(
    parameter int AW          = 6,
    parameter int DW          = 16,
    parameter int PB          = 3,
    parameter int PROG_CYCLES = 2000
) (
    input  logic clk,
    input  logic rst,
    input  logic sel,
    input  logic sclk,
    input  logic sdi,
    input  logic dl_en,
    output logic sdo,
    output logic sdo_en
);
    localparam int CW = $clog2((DW > AW) ? DW : AW);

    // Pin history and edges
    logic [2:0] pin_dly;
    logic sk_rise, cs_rise, cs_fall, dd_rise;

    mwm_sample_reg #(.N(3)) u_pins (
        .clk (clk),
        .rst (rst),
        .din ({dl_en, sel, sclk}),
        .dly (pin_dly)
    );

    assign sk_rise = sclk  & ~pin_dly[0];
    assign cs_rise = sel   & ~pin_dly[1];
    assign cs_fall = ~sel  &  pin_dly[1];
    assign dd_rise = dl_en & ~pin_dly[2];

    // Front-end state
    mw_state_e     state_q;
    logic [CW-1:0] cnt_q;
    logic [1:0]    opc_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] sh_q;
    logic [DW-1:0] wbuf_q;
    logic          dout_q;
    logic          wen_q;
    logic          stat_q;
    logic          arm_q;
    logic          dl_act_q;
    logic          fill_q;

    // Datapath
    logic          busy, prog_done, pending, launch;
    logic [AW-1:0] addr_in, fetch_addr;
    logic [DW-1:0] word_in, rd_data;
    logic          dl_start, adr_done, word_done;
    logic          stg_word, stg_erase, stg_fill;

    assign addr_in = {addr_q[AW-2:0], sdi};
    assign word_in = {wbuf_q[DW-2:0], sdi};

    assign dl_start  = sel && cs_rise && arm_q && !dl_act_q && (state_q == S_IDLE) && !busy;
    assign adr_done  = sel && sk_rise && (state_q == S_ADR)   && (cnt_q == CW'(AW-1));
    assign word_done = sel && sk_rise && (state_q == S_WDATA) && (cnt_q == CW'(DW-1));

    assign stg_word  = word_done && !fill_q;
    assign stg_fill  = word_done &&  fill_q;
    assign stg_erase = adr_done && (mw_op_e'(opc_q) == OP_ERASE) && wen_q;

    assign launch = cs_fall && pending && !busy;

    always_comb begin
        unique case (state_q)
            S_RD:    fetch_addr = addr_q + 1'b1;
            S_ADR:   fetch_addr = addr_in;
            default: fetch_addr = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= S_IDLE;
            cnt_q    <= '0;
            opc_q    <= '0;
            addr_q   <= '0;
            sh_q     <= '0;
            wbuf_q   <= '0;
            dout_q   <= 1'b0;
            wen_q    <= 1'b0;
            stat_q   <= 1'b0;
            arm_q    <= 1'b0;
            dl_act_q <= 1'b0;
            fill_q   <= 1'b0;
        end else begin
            if (!dl_en)       arm_q <= 1'b0;
            else if (dd_rise) arm_q <= 1'b1;

            if (cs_fall) begin
                state_q <= S_IDLE;
                cnt_q   <= '0;
                fill_q  <= 1'b0;
                if (dl_act_q) begin
                    dl_act_q <= 1'b0;
                    arm_q    <= 1'b0;
                end
                if (launch) stat_q <= 1'b1;
            end else if (dl_start) begin
                dl_act_q <= 1'b1;
                state_q  <= S_RD;
                addr_q   <= '0;
                sh_q     <= rd_data;
                dout_q   <= 1'b0;
                cnt_q    <= '0;
            end else if (sel && sk_rise) begin
                unique case (state_q)
                    S_IDLE: begin
                        if (sdi && !busy) begin
                            state_q <= S_OPC;
                            cnt_q   <= '0;
                            stat_q  <= 1'b0;
                        end
                    end
                    S_OPC: begin
                        opc_q <= {opc_q[0], sdi};
                        cnt_q <= cnt_q + 1'b1;
                        if (cnt_q == CW'(1)) begin
                            state_q <= S_ADR;
                            cnt_q   <= '0;
                        end
                    end
                    S_ADR: begin
                        addr_q <= addr_in;
                        cnt_q  <= cnt_q + 1'b1;
                        if (cnt_q == CW'(AW-1)) begin
                            cnt_q <= '0;
                            unique case (mw_op_e'(opc_q))
                                OP_READ: begin
                                    state_q <= S_RD;
                                    sh_q    <= rd_data;
                                    dout_q  <= 1'b0;
                                end
                                OP_WRITE: state_q <= wen_q ? S_WDATA : S_SKIP;
                                OP_ERASE: state_q <= S_SKIP;
                                default: begin
                                    state_q <= S_SKIP;
                                    unique case (mw_ext_e'(addr_in[AW-1 -: 2]))
                                        X_WOPEN: wen_q <= 1'b1;
                                        X_WPROT: wen_q <= 1'b0;
                                        X_FILL: begin
                                            if (wen_q) begin
                                                state_q <= S_WDATA;
                                                fill_q  <= 1'b1;
                                            end
                                        end
                                        default: ;
                                    endcase
                                end
                            endcase
                        end
                    end
                    S_RD: begin
                        dout_q <= sh_q[DW-1];
                        sh_q   <= {sh_q[DW-2:0], 1'b0};
                        cnt_q  <= cnt_q + 1'b1;
                        if (cnt_q == CW'(DW-1)) begin
                            cnt_q  <= '0;
                            addr_q <= addr_q + 1'b1;
                            sh_q   <= rd_data;
                        end
                    end
                    S_WDATA: begin
                        wbuf_q <= word_in;
                        cnt_q  <= cnt_q + 1'b1;
                        if (cnt_q == CW'(DW-1)) begin
                            cnt_q <= '0;
                            if (fill_q) state_q <= S_SKIP;
                            else addr_q <= {addr_q[AW-1:PB], addr_q[PB-1:0] + 1'b1};
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    mwm_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .load (launch),
        .busy (busy),
        .done (prog_done)
    );

    mwm_store #(.AW(AW), .DW(DW), .PB(PB)) u_store (
        .clk       (clk),
        .rst       (rst),
        .rd_addr   (fetch_addr),
        .rd_data   (rd_data),
        .stg_word  (stg_word),
        .stg_erase (stg_erase),
        .stg_fill  (stg_fill),
        .stg_addr  ((state_q == S_WDATA) ? addr_q : addr_in),
        .stg_data  (word_in),
        .commit    (prog_done),
        .pending   (pending)
    );

    assign sdo_en = sel && ((state_q == S_RD) || ((state_q == S_IDLE) && stat_q));
    assign sdo    = (state_q == S_RD) ? dout_q : !busy;
endmodule

// File: rtl/mwm_check.sv
module mwm_check
    import mwm_pkg::*;
#(
    parameter int AW = 6,
    parameter int PB = 3
) (
    input logic          clk,
    input logic          rst,
    input logic          sel,
    input logic          sdo_en,
    input logic          busy,
    input logic          cs_fall,
    input logic          wen,
    input logic          dl_start,
    input mw_state_e     state,
    input logic [AW-1:0] addr
);
    // R2: output floats whenever deselected
    p_hiz_desel_r2: assert property (@(posedge clk) disable iff (rst)
        !sel |-> !sdo_en);

    // R5: programming only begins at a deselect edge
    p_busy_start_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(cs_fall));

    // R6: programming never begins with the protect latch closed
    p_launch_wen_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> wen);

    // R11: protect latch closed right after reset
    p_wp_reset_r11: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !wen);

    // R10: no start bit accepted while busy
    p_idle_busy_r10: assert property (@(posedge clk) disable iff (rst)
        (busy && sel && state == S_IDLE) |=> (state == S_IDLE));

    // R4: page number fixed while data words arrive
    p_page_fixed_r4: assert property (@(posedge clk) disable iff (rst)
        (state == S_WDATA && $past(state) == S_WDATA) |-> (addr[AW-1:PB] == $past(addr[AW-1:PB])));

    // R8: download stream starts at address zero
    p_dl_zero_r8: assert property (@(posedge clk) disable iff (rst)
        dl_start |=> (state == S_RD && addr == '0));
endmodule

bind serial_cfg_mem mwm_check #(.AW(AW), .PB(PB)) u_mwm_check (
    .clk      (clk),
    .rst      (rst),
    .sel      (sel),
    .sdo_en   (sdo_en),
    .busy     (busy),
    .cs_fall  (cs_fall),
    .wen      (wen_q),
    .dl_start (dl_start),
    .state    (state_q),
    .addr     (addr_q)
);

// File: tb/test_serial_cfg_mem.sv
module test_serial_cfg_mem;
    localparam int AW   = 6;
    localparam int DW   = 16;
    localparam int PB   = 3;
    localparam int PROG = 200;

    logic clk = 1'b0, rst = 1'b1, sel = 1'b0, sclk = 1'b0, sdi = 1'b0, dl_en = 1'b0;
    logic sdo, sdo_en;

    always #10 clk = ~clk;

    serial_cfg_mem #(.AW(AW), .DW(DW), .PB(PB), .PROG_CYCLES(PROG)) i_serial_cfg_mem (
        .clk    (clk),
        .rst    (rst),
        .sel    (sel),
        .sclk   (sclk),
        .sdi    (sdi),
        .dl_en  (dl_en),
        .sdo    (sdo),
        .sdo_en (sdo_en)
    );

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;
    logic [DW-1:0] model [64];
    logic model_wen;

    // {leading zeros, address, data}
    localparam logic [23:0] VEC [6] = '{
        {2'd0, 6'd0,  16'hA5C3},
        {2'd2, 6'd1,  16'h0F1E},
        {2'd1, 6'd63, 16'h8001},
        {2'd3, 6'd21, 16'h7FFE},
        {2'd0, 6'd42, 16'h3C3C},
        {2'd1, 6'd8,  16'h1357}
    };

    task automatic tick(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic pulse(input logic b);
        sdi = b; tick(2); sclk = 1'b1; tick(2); sclk = 1'b0; tick(2);
    endtask

    task automatic select();
        sel = 1'b1; tick(2);
    endtask

    task automatic deselect();
        sel = 1'b0; sdi = 1'b0; tick(2);
    endtask

    task automatic cmd(input int lead, input logic [1:0] op, input logic [5:0] a);
        for (int i = 0; i < lead; i++) pulse(1'b0);
        pulse(1'b1);
        for (int i = 1; i >= 0; i--) pulse(op[i]);
        for (int i = 5; i >= 0; i--) pulse(a[i]);
    endtask

    task automatic send_word(input logic [DW-1:0] d);
        for (int i = DW - 1; i >= 0; i--) pulse(d[i]);
    endtask

    task automatic write_op(input int lead, input logic [5:0] a, input logic [DW-1:0] d);
        select(); cmd(lead, 2'b01, a); send_word(d); deselect();
        tick(PROG + 10);
        if (model_wen) model[a] = d;
    endtask

    task automatic read_start(input int lead, input logic [5:0] a, input string req);
        select(); cmd(lead, 2'b10, a);
        check(req, {30'd0, sdo_en, sdo}, 32'h2);
    endtask

    task automatic read_next(output logic [DW-1:0] w);
        for (int i = DW - 1; i >= 0; i--) begin pulse(1'b0); w[i] = sdo; end
    endtask

    task automatic read_word(input int lead, input logic [5:0] a, input string req);
        logic [DW-1:0] w;
        read_start(lead, a, req);
        read_next(w);
        check(req, {16'd0, w}, {16'd0, model[a]});
        deselect();
    endtask

    task automatic ext_cmd(input logic [5:0] x);
        select(); cmd(0, 2'b00, x); deselect();
    endtask

    initial begin
        logic [DW-1:0] w;
        for (int i = 0; i < 64; i++) model[i] = '1;
        model_wen = 1'b0;
        tick(5); rst = 1'b0; tick(2);

        // R11: reset state
        check("R11 sdo_en after reset", {31'd0, sdo_en}, 32'd0);
        read_word(0, 6'd5, "R11 erased content");

        // R6: write while protected has no effect
        write_op(0, 6'd3, 16'hBEEF);
        read_word(0, 6'd3, "R6 protected write ignored");

        ext_cmd(6'b110000); model_wen = 1'b1;

        // R1 R2: table of writes and readbacks, with leading zeros
        for (int k = 0; k < 6; k++) begin
            write_op(int'(VEC[k][23:22]), VEC[k][21:16], VEC[k][15:0]);
            read_word(int'(VEC[k][23:22]), VEC[k][21:16], "R1 R2 table readback");
        end
        check("R2 output floats when deselected", {31'd0, sdo_en}, 32'd0);

        // R3: streamed read wraps 63 -> 0
        read_start(0, 6'd63, "R3 dummy bit");
        read_next(w); check("R3 word at 63", {16'd0, w}, {16'd0, model[63]});
        read_next(w); check("R3 wrap to 0",  {16'd0, w}, {16'd0, model[0]});
        deselect();

        // R8: download mode
        dl_en = 1'b1; tick(3);
        sel = 1'b1; tick(3);
        check("R8 download dummy", {30'd0, sdo_en, sdo}, 32'h2);
        read_next(w); check("R8 download word 0", {16'd0, w}, {16'd0, model[0]});
        read_next(w); check("R8 download word 1", {16'd0, w}, {16'd0, model[1]});
        sel = 1'b0; tick(2); sel = 1'b1; tick(3);
        check("R8 download exited", {31'd0, sdo_en}, 32'd0);
        sel = 1'b0; dl_en = 1'b0; tick(2);

        // R4 R5 R10: page write wrapping, status display, ignored command while busy
        select(); cmd(0, 2'b01, 6'd6);
        send_word(16'h1111); send_word(16'h2222); send_word(16'h3333);
        deselect();
        tick(3); select();
        check("R5 busy status", {30'd0, sdo_en, sdo}, 32'h2);
        cmd(0, 2'b00, 6'b000000);   // write-disable sent while busy: R10
        deselect();
        tick(PROG); select();
        check("R5 ready status", {30'd0, sdo_en, sdo}, 32'h3);
        pulse(1'b1);
        check("R5 status ends at start bit", {31'd0, sdo_en}, 32'd0);
        deselect();
        model[6] = 16'h1111; model[7] = 16'h2222; model[0] = 16'h3333;
        read_word(0, 6'd6, "R4 page slot 6");
        read_word(0, 6'd7, "R4 page slot 7");
        read_word(0, 6'd0, "R4 page wrap to slot 0");
        read_word(0, 6'd8, "R4 next page untouched");
        write_op(0, 6'd21, 16'hCAFE);
        read_word(0, 6'd21, "R10 busy command ignored");

        // R9: partial command discarded on deselect
        select(); pulse(1'b1); pulse(1'b1); pulse(1'b0); pulse(1'b1); deselect();
        select(); pulse(1'b0); pulse(1'b0); pulse(1'b0);
        check("R9 no continuation", {31'd0, sdo_en}, 32'd0);
        deselect();
        read_word(0, 6'd21, "R9 fresh command");

        // R7: erase and fill
        select(); cmd(0, 2'b11, 6'd42); deselect(); tick(PROG + 10);
        model[42] = '1;
        read_word(0, 6'd42, "R7 erase gives ones");
        select(); cmd(0, 2'b00, 6'b010000); send_word(16'h5A69); deselect(); tick(PROG + 10);
        for (int i = 0; i < 64; i++) model[i] = 16'h5A69;
        read_word(0, 6'd9,  "R7 fill word 9");
        read_word(0, 6'd63, "R7 fill word 63");

        // R6: disable again, writes and erase ignored, reads still work
        ext_cmd(6'b000000); model_wen = 1'b0;
        write_op(0, 6'd9, 16'h0000);
        read_word(0, 6'd9, "R6 write after disable");
        select(); cmd(0, 2'b11, 6'd10); deselect(); tick(PROG + 10);
        read_word(0, 6'd10, "R6 erase after disable");

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule